// File: doc/BRIEF.md
# Instruction-Scheduled Crossbar Router

This block is the scheduled word router of one tile in a two-dimensional mesh. Nothing in the data decides where a word goes. A local program fixes the routes ahead of time. A sequencer steps through a program memory of 64-bit instructions. Each instruction names one source for every crossbar output and carries one small control command. The crossbar has seven endpoints:

- the four mesh neighbours;
- the tile's compute processor;
- a companion crossbar;
- the router's own pipeline, which is a small register file that can both supply and absorb words.

Every external link carries one 32-bit word under a valid/ready handshake. The route is known before the word arrives, so the data path from a source to its destinations has no register and a word leaves in the cycle it is presented. The sequencer moves to the next instruction only after every route of the current one has delivered its word. A route that has already delivered is not repeated while the others wait. A write port fills the program memory, normally while the block is held in reset. The commands are conditional and unconditional branches (one of them with counter decrement) and a load of a register with an immediate value.

Top module: `srt_router`

## Requirements
- R1: While reset is low the program counter is 0, all four 32-bit registers are 0 and no route is marked as delivered; the first instruction after reset sees these values.
- R2: Bits [3o+2:3o] of an instruction hold the source code of output o. Outputs 0..5 are the external links in the order north, east, south, west, processor, companion; output 6 writes the register chosen by bits [60:59]. Source code 0 means no route, codes 1..6 select external input link 0..5, and code 7 selects the value of the register chosen by bits [60:59].
- R3: A routed output that has not yet delivered in the current instruction shows, in the same cycle, the valid bit and the data of its source. The register source is always valid and the register sink is always ready.
- R4: An input link sees ready only when at least one output still waiting in the current instruction selects it and every such output is ready in that cycle. An input link that no waiting output selects never sees ready, so its word stays in place.
- R5: An output that has delivered its word during the current instruction shows no valid again until the instruction changes.
- R6: The instruction advances on the clock edge at which every output is unrouted, already delivered or delivering. Otherwise the program counter holds. An instruction with no routes takes exactly one cycle.
- R7: Bits [63:61] hold the command: 0 none, 1 jump, 2 branch-if-nonzero-and-decrement, 3 branch-if-zero, 4 branch-if-nonzero, 5 load-immediate, 6 and 7 none. A taken branch loads the program counter with the low bits of field [58:43]. Otherwise the counter steps by one and wraps at the end of the memory.
- R8: Commands act only at the advancing edge and test the chosen register's value from before that edge. Branch-if-nonzero-and-decrement writes value minus one only when taken. Load-immediate writes bits [42:27] zero-extended.
- R9: A word routed to output 6 is written into the chosen register at the edge where it is delivered. When a command write to the same register falls on that edge, the command's value is kept.
- R10: A write through the program port stores the word at the given address at the clock edge. Writes are accepted while reset is low, and the stored program is in effect from the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_we | input | 1 | Program memory write enable |
| prog_addr | input | AW (8) | Program memory write address |
| prog_data | input | 64 | Instruction word to store |
| link_in_data | input | 6*32 | Input words, link k at bits [32k+31:32k] |
| link_in_valid | input | 6 | Input word present, one bit per link |
| link_in_ready | output | 6 | Input word taken, one bit per link |
| link_out_data | output | 6*32 | Output words, link k at bits [32k+31:32k] |
| link_out_valid | output | 6 | Output word present, one bit per link |
| link_out_ready | input | 6 | Output link can accept, one bit per link |
| pc | output | AW (8) | Address of the instruction in effect |

## Verification
Link valid, ready and data are combinational functions of the current instruction and the link inputs, so they are due in the same cycle as the stimulus. The program counter, the delivered marks and the registers change one clock edge after the cycle that caused them. The bench therefore drives every input just after the falling edge and samples one time unit later, well before the next rising edge. At that sample point it compares the links against a model of the current cycle. It then moves the model forward to the state it expects after the coming edge, so the program counter and register values it checks in the next cycle include exactly one edge of effect.

// File: rtl/srt_pkg.sv
package srt_pkg;
  localparam int WORD_W   = 32;
  localparam int INSTR_W  = 64;
  localparam int N_EXT    = 6;            // external links
  localparam int N_END    = N_EXT + 1;    // plus the register endpoint
  localparam int SEL_W    = 3;
  localparam int ROUTE_W  = N_END * SEL_W;
  localparam int N_REG    = 4;
  localparam int RSEL_W   = $clog2(N_REG);
  localparam int OP_LSB   = 61;
  localparam int RSEL_LSB = 59;
  localparam int TGT_LSB  = 43;
  localparam int TGT_W    = 16;
  localparam int IMM_LSB  = 27;
  localparam int IMM_W    = 16;
  localparam int SPARE_W  = IMM_LSB - ROUTE_W;

  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_JMP  = 3'd1,
    OP_BNZD = 3'd2,
    OP_BZ   = 3'd3,
    OP_BNZ  = 3'd4,
    OP_LDI  = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } op_e;

  // Source code to endpoint slot; code 0 maps to a harmless slot.
  function automatic logic [SEL_W-1:0] src_slot(logic [SEL_W-1:0] code);
    return (code == '0) ? '0 : code - 1'b1;
  endfunction

  function automatic logic br_taken(op_e op, logic nz);
    case (op)
      OP_JMP:          return 1'b1;
      OP_BZ:           return !nz;
      OP_BNZ, OP_BNZD: return nz;
      default:         return 1'b0;
    endcase
  endfunction

  function automatic logic cmd_writes(op_e op, logic nz);
    return (op == OP_LDI) || (op == OP_BNZD && nz);
  endfunction

  function automatic logic [WORD_W-1:0] cmd_value(op_e op, logic [WORD_W-1:0] cur,
                                                  logic [IMM_W-1:0] imm);
    return (op == OP_LDI) ? {{(WORD_W-IMM_W){1'b0}}, imm} : cur - 1'b1;
  endfunction
endpackage

// File: rtl/srt_imem.sv
module srt_imem
  import srt_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               we,
  input  logic [AW-1:0]      waddr,
  input  logic [INSTR_W-1:0] wdata,
  input  logic [AW-1:0]      raddr,
  output logic [INSTR_W-1:0] rdata
);
  logic [INSTR_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/srt_xbar.sv
module srt_xbar
  import srt_pkg::*;
(
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [ROUTE_W-1:0]                routes,
  input  logic [N_END-1:0][WORD_W-1:0]      src_data,
  input  logic [N_END-1:0]                  src_valid,
  input  logic [N_END-1:0]                  dst_ready,
  output logic [N_END-1:0][WORD_W-1:0]      dst_data,
  output logic [N_END-1:0]                  dst_valid,
  output logic [N_END-1:0]                  dst_fire,
  output logic [N_EXT-1:0]                  src_ready,
  output logic                              advance
);
  logic [N_END-1:0] done_q;
  logic [N_END-1:0] idle;
  logic [N_END-1:0] complete;

  for (genvar o = 0; o < N_END; o++) begin : g_out
    logic [SEL_W-1:0] code;
    logic [SEL_W-1:0] slot;
    assign code         = routes[o*SEL_W +: SEL_W];
    assign slot         = src_slot(code);
    assign idle[o]      = (code == '0);
    assign dst_data[o]  = idle[o] ? '0 : src_data[slot];
    assign dst_valid[o] = !idle[o] && src_valid[slot] && !done_q[o];
    assign dst_fire[o]  = dst_valid[o] && dst_ready[o];
    assign complete[o]  = idle[o] || done_q[o] || dst_fire[o];
  end

  // A source is taken only when all of its still-waiting outputs accept together.
  for (genvar s = 0; s < N_EXT; s++) begin : g_src
    logic [N_END-1:0] wants;
    logic [N_END-1:0] blocks;
    always_comb begin
      wants  = '0;
      blocks = '0;
      for (int k = 0; k < N_END; k++) begin
        if (routes[k*SEL_W +: SEL_W] == SEL_W'(s + 1) && !done_q[k]) begin
          wants[k]  = 1'b1;
          blocks[k] = !dst_ready[k];
        end
      end
    end
    assign src_ready[s] = (|wants) && !(|blocks);
  end

  assign advance = &complete;

  always_ff @(posedge clk) begin
    if (!rst_n)       done_q <= '0;
    else if (advance) done_q <= '0;
    else              done_q <= done_q | dst_fire;
  end
endmodule

// File: rtl/srt_seq.sv
module srt_seq
  import srt_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              advance,
  input  op_e               op,
  input  logic [RSEL_W-1:0] rsel,
  input  logic [AW-1:0]     tgt,
  input  logic [IMM_W-1:0]  imm,
  input  logic              sink_fire,
  input  logic [WORD_W-1:0] sink_data,
  output logic [AW-1:0]     pc,
  output logic [WORD_W-1:0] reg_rd
);
  logic [N_REG-1:0][WORD_W-1:0] rf_q;
  logic [AW-1:0]                pc_q;
  logic                         nz;
  logic                         taken;
  logic                         cmd_wr;
  logic [WORD_W-1:0]            cmd_val;

  assign reg_rd  = rf_q[rsel];
  assign nz      = (reg_rd != '0);
  assign taken   = br_taken(op, nz);
  assign cmd_wr  = advance && cmd_writes(op, nz);
  assign cmd_val = cmd_value(op, reg_rd, imm);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rf_q <= '0;
      pc_q <= '0;
    end else begin
      if (sink_fire) rf_q[rsel] <= sink_data;
      if (cmd_wr)    rf_q[rsel] <= cmd_val;   // later assignment: command wins
      if (advance)   pc_q <= taken ? tgt : pc_q + 1'b1;
    end
  end

  assign pc = pc_q;
endmodule

// File: rtl/srt_router.sv
module srt_router
  import srt_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    prog_we,
  input  logic [AW-1:0]           prog_addr,
  input  logic [INSTR_W-1:0]      prog_data,
  input  logic [N_EXT*WORD_W-1:0] link_in_data,
  input  logic [N_EXT-1:0]        link_in_valid,
  output logic [N_EXT-1:0]        link_in_ready,
  output logic [N_EXT*WORD_W-1:0] link_out_data,
  output logic [N_EXT-1:0]        link_out_valid,
  input  logic [N_EXT-1:0]        link_out_ready,
  output logic [AW-1:0]           pc
);
  logic [INSTR_W-1:0]              instr;
  logic [N_END-1:0][WORD_W-1:0]    src_data;
  logic [N_END-1:0][WORD_W-1:0]    dst_data;
  logic [N_END-1:0]                src_valid;
  logic [N_END-1:0]                dst_ready;
  logic [N_END-1:0]                dst_valid;
  logic [N_END-1:0]                dst_fire;
  logic [WORD_W-1:0]               reg_rd;
  logic                            advance;

  srt_imem #(.DEPTH(DEPTH)) u_imem (
    .clk   (clk),
    .we    (prog_we),
    .waddr (prog_addr),
    .wdata (prog_data),
    .raddr (pc),
    .rdata (instr)
  );

  assign src_data  = {reg_rd, link_in_data};
  assign src_valid = {1'b1, link_in_valid};
  assign dst_ready = {1'b1, link_out_ready};

  srt_xbar u_xbar (
    .clk       (clk),
    .rst_n     (rst_n),
    .routes    (instr[ROUTE_W-1:0]),
    .src_data  (src_data),
    .src_valid (src_valid),
    .dst_ready (dst_ready),
    .dst_data  (dst_data),
    .dst_valid (dst_valid),
    .dst_fire  (dst_fire),
    .src_ready (link_in_ready),
    .advance   (advance)
  );

  srt_seq #(.AW(AW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .advance   (advance),
    .op        (op_e'(instr[OP_LSB +: 3])),
    .rsel      (instr[RSEL_LSB +: RSEL_W]),
    .tgt       (instr[TGT_LSB +: AW]),
    .imm       (instr[IMM_LSB +: IMM_W]),
    .sink_fire (dst_fire[N_EXT]),
    .sink_data (dst_data[N_EXT]),
    .pc        (pc),
    .reg_rd    (reg_rd)
  );

  assign link_out_data  = dst_data[N_EXT-1:0];
  assign link_out_valid = dst_valid[N_EXT-1:0];

  wire unused_bits = ^{instr[ROUTE_W +: SPARE_W], instr[TGT_LSB+AW +: TGT_W-AW],
                       dst_valid[N_EXT]};
endmodule

// File: rtl/srt_router_chk.sv
module srt_router_chk
  import srt_pkg::*;
#(
  parameter int AW = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [AW-1:0]      pc,
  input logic               advance,
  input logic [N_END-1:0]   fire,
  input logic [N_END-1:0]   valid,
  input logic [ROUTE_W-1:0] routes
);
  logic [N_END-1:0] none_mask;
  for (genvar o = 0; o < N_END; o++) begin : g_none
    assign none_mask[o] = (routes[o*SEL_W +: SEL_W] == '0);
  end

  AST_PC_AT_RESET: assert property (@(posedge clk)
    !rst_n |=> pc == '0);                                                      // R1

  AST_NONE_NEVER_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (valid & none_mask) == '0);                                                // R2

  AST_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (|fire && !advance) |=> ((valid & $past(fire)) == '0));                     // R5

  AST_PC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(pc));                                                 // R6

  AST_EMPTY_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    (&none_mask) |-> advance);                                                 // R6
endmodule

bind srt_router srt_router_chk #(.AW(AW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .pc      (pc),
  .advance (advance),
  .fire    (dst_fire),
  .valid   (dst_valid),
  .routes  (instr[srt_pkg::ROUTE_W-1:0])
);

// File: tb/srt_router_bench.sv
module srt_router_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 256;
  localparam int AW = 8;
  localparam int NX = 6;
  localparam int NE = 7;
  localparam int CYCLES = 4000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic prog_we = 1'b0;
  logic [AW-1:0] prog_addr = '0;
  logic [63:0] prog_data = '0;
  logic [NX*32-1:0] link_in_data = '0;
  logic [NX-1:0] link_in_valid = '0;
  logic [NX-1:0] link_in_ready;
  logic [NX*32-1:0] link_out_data;
  logic [NX-1:0] link_out_valid;
  logic [NX-1:0] link_out_ready = '0;
  logic [AW-1:0] pc;

  always #(CLK_PERIOD/2) clk = ~clk;

  srt_router #(.DEPTH(DEPTH)) u_srt_router (
    .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_addr(prog_addr),
    .prog_data(prog_data), .link_in_data(link_in_data), .link_in_valid(link_in_valid),
    .link_in_ready(link_in_ready), .link_out_data(link_out_data),
    .link_out_valid(link_out_valid), .link_out_ready(link_out_ready), .pc(pc)
  );

  int n_cmp = 0;
  int n_bad = 0;

  logic [63:0] prog [DEPTH];
  bit   [NX-1:0] bv;
  logic [31:0] bd [NX];
  logic [31:0] mreg [4];
  bit   [NE-1:0] rcvd;
  int   pcm;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h (pc=%0d)", req, act, exp, pcm);
    end
  endtask

  // Bench-side instruction assembly
  function automatic logic [63:0] mk(input int op, input int rs, input int tgt,
                                     input int imm, input logic [20:0] rt);
    logic [63:0] w;
    w = '0;
    w[63:61] = op[2:0];
    w[60:59] = rs[1:0];
    w[58:43] = tgt[15:0];
    w[42:27] = imm[15:0];
    w[20:0]  = rt;
    return w;
  endfunction

  function automatic logic [20:0] rte(input logic [20:0] rt, input int o, input int code);
    logic [20:0] r;
    r = rt;
    r[o*3 +: 3] = code[2:0];
    return r;
  endfunction

  function automatic bit exp_taken(input int op, input bit nz);
    if (op == 1) return 1'b1;
    if (op == 3) return !nz;
    if (op == 2 || op == 4) return nz;
    return 1'b0;
  endfunction

  function automatic logic [63:0] rand_instr();
    logic [20:0] rt;
    rt = '0;
    for (int o = 0; o < NE; o++)
      if ($urandom % 2) rt = rte(rt, o, int'($urandom_range(1, 7)));
    return mk(int'($urandom % 8), int'($urandom % 4), int'($urandom % DEPTH),
              int'($urandom % 65536), rt);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R6 watchdog: actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4127));
    for (int a = 0; a < DEPTH; a++) prog[a] = rand_instr();
    // directed corner cases
    prog[0] = mk(0, 3, 0, 0, rte(21'd0, 3, 7));                     // west <- r3 (reset value)
    prog[1] = mk(5, 1, 0, 3, 21'd0);                                // load r1=3, no routes
    prog[2] = mk(2, 1, 2, 0, rte(21'd0, 4, 7));                     // proc <- r1, decrement loop
    prog[3] = mk(0, 2, 0, 0, rte(rte(rte(21'd0, 0, 5), 1, 5), 6, 1)); // fan-out, north -> r2
    prog[4] = mk(3, 3, 6, 0, 21'd0);                                // branch-if-zero on r3
    prog[6] = mk(5, 0, 0, 16'h1234, rte(21'd0, 6, 2));              // sink and load same reg
    prog[7] = mk(1, 0, 9, 0, rte(21'd0, 3, 7));                     // west <- r0, jump 9
    prog[DEPTH-1] = mk(1, 0, 0, 0, 21'd0);

    // R10: program loaded while reset is held
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk);
      prog_we = 1'b1; prog_addr = AW'(a); prog_data = prog[a];
    end
    @(negedge clk);
    prog_we = 1'b0;
    bv = '0; rcvd = '0; pcm = 0;
    for (int r = 0; r < 4; r++) mreg[r] = '0;
    rst_n = 1'b1;
    #1;
    check(pc == '0, "R1 pc after reset", 64'(pc), 64'd0);
    check(link_out_valid[3] == 1'b1, "R10 loaded entry 0 in effect", 64'(link_out_valid[3]), 64'd1);

    for (int cyc = 0; cyc < CYCLES; cyc++) begin
      logic [63:0] ins;
      int f [NE];
      bit sv [NE];
      logic [31:0] sd [NE];
      bit drdy [NE];
      bit ov [NE];
      bit fire [NE];
      bit [NX-1:0] irdy;
      bit adv;
      int op, rs;
      logic [31:0] cur;

      for (int s = 0; s < NX; s++) begin
        if (!bv[s] && ($urandom % 10) < 7) begin bv[s] = 1'b1; bd[s] = $urandom; end
        link_in_valid[s] = bv[s];
        link_in_data[s*32 +: 32] = bd[s];
        link_out_ready[s] = (($urandom % 10) < 6);
      end
      #1;
      ins = prog[pcm];
      op  = int'(ins[63:61]);
      rs  = int'(ins[60:59]);
      check(int'(pc) == pcm, "R6 R7 program counter", 64'(pc), 64'(pcm));
      for (int o = 0; o < NE; o++) begin
        f[o]    = int'(ins[o*3 +: 3]);
        drdy[o] = (o == NX) ? 1'b1 : link_out_ready[o];
        sv[o]   = (f[o] == 7) ? 1'b1 : (f[o] == 0) ? 1'b0 : bv[f[o]-1];
        sd[o]   = (f[o] == 7) ? mreg[rs] : (f[o] == 0) ? 32'd0 : bd[f[o]-1];
        ov[o]   = (f[o] != 0) && sv[o] && !rcvd[o];
        fire[o] = ov[o] && drdy[o];
      end
      for (int s = 0; s < NX; s++) begin
        bit used, ok;
        used = 1'b0; ok = 1'b1;
        for (int o = 0; o < NE; o++)
          if (f[o] == s + 1 && !rcvd[o]) begin used = 1'b1; ok = ok && drdy[o]; end
        irdy[s] = used && ok;
      end
      adv = 1'b1;
      for (int o = 0; o < NE; o++) if (!(f[o] == 0 || rcvd[o] || fire[o])) adv = 1'b0;

      for (int o = 0; o < NX; o++) begin
        check(link_out_valid[o] == ov[o], "R3 R5 output valid", 64'(link_out_valid[o]), 64'(ov[o]));
        if (ov[o])
          check(link_out_data[o*32 +: 32] == sd[o],
                (f[o] == 7) ? ((pcm == 0) ? "R1 register reset value" : "R8 R9 register word")
                            : "R2 R3 routed word",
                64'(link_out_data[o*32 +: 32]), 64'(sd[o]));
      end
      check(link_in_ready == irdy, "R4 input ready", 64'(link_in_ready), 64'(irdy));

      // advance model across the coming edge
      cur = mreg[rs];
      if (fire[NX]) mreg[rs] = sd[NX];
      for (int s = 0; s < NX; s++) if (bv[s] && irdy[s]) bv[s] = 1'b0;
      for (int o = 0; o < NE; o++) if (fire[o]) rcvd[o] = 1'b1;
      if (adv) begin
        rcvd = '0;
        if (op == 5) mreg[rs] = {16'd0, ins[42:27]};
        else if (op == 2 && cur != 0) mreg[rs] = cur - 1;
        pcm = exp_taken(op, cur != 0) ? int'(ins[50:43]) : (pcm + 1) % DEPTH;
      end
      @(negedge clk);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule